// File: doc/BRIEF.md
# PHY Management Register Bank

This block holds the sixteen-bit management registers of a gigabit Ethernet PHY. An MDIO slave that decodes serial frames drives it through a simple register port. A single-cycle request carries a 5-bit register address, a write flag and write data. Reads return the selected word one clock later together with a valid strobe.

Each address has an access rule:

- Writable registers store what is written.
- Read-only registers return fixed values and drop writes.
- The write-only page-select slot reads as zero.
- Unimplemented slots and addresses outside the map read zero and drop writes.

The two identifier registers come from parameters. The first holds bits 18 down to 3 of the vendor OUI. The second holds a configurable extended identifier.

The status register carries a link bit that latches low. Once the link-up input has been seen low, the bit reads 0 until the status register is read. The read after that reports the live link state. Writing the control register with its top bit set performs a software reset. Every stored register returns to its default, the link latch drops low, and the reset bit reads back as 0.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After hardware reset the registers read as follows:
  - address 0 (control): 0x1140
  - address 1 (status): 0x7949, with the link bit (bit 2) at 0
  - address 2: OUI[18:3], which is 0x0A08 for OUI 0x005043
  - address 3: the EXT_ID parameter
  - address 4: 0x0DE1
  - address 9: 0x0E00
  - address 16: 0x0068
- R2: A request with we_i=0 yields rdata_o and a one-cycle rvalid_o high on the clock edge that samples the request. rvalid_o is low in every other cycle, and rdata_o holds its value when no read is made.
- R3: Addresses 4, 9 and 16 store all 16 written bits. Address 0 stores bits 14:0 when bit 15 of the write data is 0.
- R4: Writes to the read-only addresses 1, 2, 3, 5, 6, 15 and 17 leave their read values unchanged.
- R5: Address 10 always reads 0x3C00, including after a write to it.
- R6: Addresses 20, 26 and 30 read 0 and ignore writes. Addresses outside the map (for example 7 and 31) also read 0 and ignore writes.
- R7: Address 29 is write-only: writes are accepted and a read returns 0.
- R8: A write to address 0 with bit 15 set restores every stored register to its R1 default. A later read of address 0 shows bit 15 as 0.
- R9: Once link_up_i has been low at a clock edge, status bit 2 reads 0 on every status read until one status read has returned it, even if link_up_i has since gone high.
- R10: The status read that follows a latched-low read reports the link_up_i value sampled at the earlier read.
- R11: A software reset (R8) also forces the status link bit low until the next status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| link_up_i | input | 1 | Current link state from the line side |
| rdata_o | output | 16 | Read data, registered |
| rvalid_o | output | 1 | Read data valid strobe |

## Verification
The bench keeps the default OUI 0x005043 and overrides EXT_ID to 0xA5C3. A mistake that ties the second identifier to a constant therefore shows as a wrong read, and the first identifier checks the bit slice taken from the OUI. With these values every slot of the 32-entry map is within reach. That covers the stored, constant, write-only, unimplemented and unmapped kinds, plus the link latch and the software reset acting on the same register file.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned NREG   = 1 << ADDR_W;
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_STAT = 1;
  localparam int unsigned RST_BIT = DATA_W - 1;
  localparam int unsigned LINK_BIT = 2;

  typedef enum logic [2:0] {
    K_NONE, K_RW, K_RO, K_WO, K_CTRL, K_STAT, K_UNIMPL
  } reg_kind_e;

  function automatic reg_kind_e kind_of(int unsigned a);
    case (a)
      0:                     return K_CTRL;
      1:                     return K_STAT;
      2, 3, 5, 6, 10, 15, 17: return K_RO;
      4, 9, 16:              return K_RW;
      29:                    return K_WO;
      20, 26, 30:            return K_UNIMPL;
      default:               return K_NONE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] default_of(int unsigned a,
                                                   logic [23:0] oui,
                                                   logic [DATA_W-1:0] ext_id);
    case (a)
      0:       return 16'h1140;
      1:       return 16'h7949;
      2:       return oui[18:3];
      3:       return ext_id;
      4:       return 16'h0DE1;
      5:       return 16'h01E1;
      9:       return 16'h0E00;
      10:      return 16'h3C00;
      15:      return 16'h3000;
      16:      return 16'h0068;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/phy_reg_cell.sv
module phy_reg_cell #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_o <= RST;
    else if (soft_rst_i) q_o <= RST;
    else if (ld_i)       q_o <= d_i;
  end
endmodule

// File: rtl/phy_link_latch.sv
module phy_link_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic link_up_i,
  input  logic stat_rd_i,
  output logic lat_o
);
  // low sticks until the status register is read, then re-samples the link
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lat_o <= 1'b0;
    else if (soft_rst_i) lat_o <= 1'b0;
    else if (stat_rd_i)  lat_o <= link_up_i;
    else if (!link_up_i) lat_o <= 1'b0;
  end
endmodule

// File: rtl/phy_rd_path.sv
module phy_rd_path #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rd_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rdata_o,
  output logic         rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= d_i;
    end
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter logic [23:0]       OUI    = 24'h005043,
  parameter logic [DATA_W-1:0] EXT_ID = 16'h0C20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              link_up_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic rd, wr, soft_rst, stat_rd, lat;
  logic [DATA_W-1:0] rd_word [NREG];

  assign rd       = req_i & ~we_i;
  assign wr       = req_i & we_i;
  assign soft_rst = wr && (addr_i == ADDR_W'(A_CTRL)) && wdata_i[RST_BIT];
  assign stat_rd  = rd && (addr_i == ADDR_W'(A_STAT));

  for (genvar a = 0; a < NREG; a++) begin : g_reg
    localparam reg_kind_e         K    = kind_of(a);
    localparam logic [DATA_W-1:0] DFLT = default_of(a, OUI, EXT_ID);
    if (K == K_RW || K == K_CTRL) begin : g_st
      logic [DATA_W-1:0] d, q;
      logic ld;
      assign ld = wr && (addr_i == ADDR_W'(a));
      if (K == K_CTRL) begin : g_ctl
        assign d = {1'b0, wdata_i[DATA_W-2:0]};
      end else begin : g_rw
        assign d = wdata_i;
      end
      phy_reg_cell #(.W(DATA_W), .RST(DFLT)) i_cell (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .soft_rst_i(soft_rst),
        .ld_i      (ld),
        .d_i       (d),
        .q_o       (q)
      );
      assign rd_word[a] = q;
    end else if (K == K_RO) begin : g_ro
      assign rd_word[a] = DFLT;
    end else if (K == K_STAT) begin : g_stat
      assign rd_word[a] = {DFLT[DATA_W-1:LINK_BIT+1], lat, DFLT[LINK_BIT-1:0]};
    end else begin : g_zero
      assign rd_word[a] = '0;
    end
  end

  phy_link_latch i_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst),
    .link_up_i (link_up_i),
    .stat_rd_i (stat_rd),
    .lat_o     (lat)
  );

  phy_rd_path #(.W(DATA_W)) i_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd),
    .d_i     (rd_word[addr_i]),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk
  import phy_mgmt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              link_up_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o
);
  logic rd;
  assign rd = req_i && !we_i;

  // R2
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
  // R2
  no_stray_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rvalid_o);
  // R2
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
  // R5
  gstat_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == 5'd10) |=> rdata_o == 16'h3C00);
  // R6 R7
  dead_addr_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (addr_i == 5'd20 || addr_i == 5'd26 || addr_i == 5'd29 || addr_i == 5'd30))
      |=> rdata_o == '0);
  // R9
  link_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == ADDR_W'(A_STAT) && $past(!link_up_i)) |=> !rdata_o[LINK_BIT]);
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .link_up_i(link_up_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o)
);

// File: tb/test_phy_mgmt_regs.sv
module test_phy_mgmt_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] OUI_T = 24'h005043;
  localparam logic [15:0] EXT_T = 16'hA5C3;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0, link = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        rvalid;
  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mgmt_regs #(.OUI(OUI_T), .EXT_ID(EXT_T)) i_phy_mgmt_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .link_up_i(link), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  // monitor: pop expected items as read data arrives
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check("R2 stray rvalid", 16'h0001, 16'h0000);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rdata, e);
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset rvalid", {15'd0, rvalid}, 16'h0000);
    check("R1 reset rdata", rdata, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 defaults
    rd_chk(5'd0,  16'h1140, "R1 ctrl");
    rd_chk(5'd1,  16'h7949, "R1 status");
    rd_chk(5'd2,  OUI_T[18:3], "R1 id1");
    rd_chk(5'd3,  EXT_T, "R1 id2");
    rd_chk(5'd4,  16'h0DE1, "R1 adv");
    rd_chk(5'd9,  16'h0E00, "R1 gctl");
    rd_chk(5'd16, 16'h0068, "R1 pctl");

    // R9 latched low since reset, R10 live after
    link = 1'b1;
    @(negedge clk);
    rd_chk(5'd1, 16'h7949, "R9 latched after reset");
    rd_chk(5'd1, 16'h794D, "R10 live link");
    rd_chk(5'd1, 16'h794D, "R10 still up");
    link = 1'b0;
    @(negedge clk);
    link = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk(5'd1, 16'h7949, "R9 drop latched");
    rd_chk(5'd1, 16'h794D, "R10 recovered");

    // R3 stored registers
    wr(5'd0, 16'h0100);  rd_chk(5'd0, 16'h0100, "R3 ctrl");
    wr(5'd0, 16'h7FFF);  rd_chk(5'd0, 16'h7FFF, "R3 ctrl low bits");
    wr(5'd4, 16'h1234);  rd_chk(5'd4, 16'h1234, "R3 adv");
    wr(5'd9, 16'h0300);  rd_chk(5'd9, 16'h0300, "R3 gctl");
    wr(5'd16, 16'hFFFF); rd_chk(5'd16, 16'hFFFF, "R3 pctl");

    // R4 read-only, R5 constant
    wr(5'd1, 16'h0000);  rd_chk(5'd1, 16'h794D, "R4 status");
    wr(5'd2, 16'hFFFF);  rd_chk(5'd2, OUI_T[18:3], "R4 id1");
    wr(5'd3, 16'h0000);  rd_chk(5'd3, EXT_T, "R4 id2");
    wr(5'd5, 16'hFFFF);  rd_chk(5'd5, 16'h01E1, "R4 partner");
    wr(5'd6, 16'hFFFF);  rd_chk(5'd6, 16'h0000, "R4 expansion");
    wr(5'd15, 16'h0000); rd_chk(5'd15, 16'h3000, "R4 ext status");
    wr(5'd17, 16'hFFFF); rd_chk(5'd17, 16'h0000, "R4 phy status");
    rd_chk(5'd10, 16'h3C00, "R5 gstat");
    wr(5'd10, 16'h0000); rd_chk(5'd10, 16'h3C00, "R5 gstat after write");

    // R6 unimplemented and unmapped, R7 write-only
    wr(5'd20, 16'hFFFF); rd_chk(5'd20, 16'h0000, "R6 addr20");
    wr(5'd26, 16'hFFFF); rd_chk(5'd26, 16'h0000, "R6 addr26");
    wr(5'd30, 16'hFFFF); rd_chk(5'd30, 16'h0000, "R6 addr30");
    wr(5'd7, 16'hFFFF);  rd_chk(5'd7, 16'h0000, "R6 unmapped 7");
    wr(5'd31, 16'hFFFF); rd_chk(5'd31, 16'h0000, "R6 unmapped 31");
    wr(5'd29, 16'h5555); rd_chk(5'd29, 16'h0000, "R7 write-only");
    rd_chk(5'd4, 16'h1234, "R6 no side effect on adv");

    // R8 software reset, R11 link latch re-armed
    wr(5'd0, 16'h8000);
    rd_chk(5'd0,  16'h1140, "R8 ctrl default, bit15 clear");
    rd_chk(5'd4,  16'h0DE1, "R8 adv default");
    rd_chk(5'd9,  16'h0E00, "R8 gctl default");
    rd_chk(5'd16, 16'h0068, "R8 pctl default");
    rd_chk(5'd1,  16'h7949, "R11 link low after soft reset");
    rd_chk(5'd1,  16'h794D, "R11 link live again");

    repeat (3) @(negedge clk);
    check("R2 all reads answered", 16'(exp_q.size()), 16'h0000);
    summary();
    $finish;
  end
endmodule